// File: doc/BRIEF.md
# Byte-Bus 16-Bit Timer with Compare and Capture

The block is a 16-bit timer/counter that a processor reaches over an 8-bit register bus. It holds a counter that steps once per enable strobe, two compare units that raise flags and can toggle a waveform pin each, and a capture register. The capture register latches the counter when a selected edge arrives on either the capture pin or an alternate comparator input. The capture register can also act as the counter's wrap point.

Every 16-bit register is reached one byte at a time. A single 8-bit holding byte is shared by all of them, so each 16-bit transfer is atomic. To write, software stores the high byte, which lands in the holding byte, and then the low byte, which commits both halves in one cycle. To read, software fetches the low byte, which also snapshots the high half into the holding byte, and then fetches the high byte, which returns that snapshot.

A bus write to the counter suppresses compare matches on the next timer step. Without this, a freshly loaded value equal to a compare register would fire at once.

Top module: `tmr16_bytebus`

## Requirements
- R1: After reset the counter, the capture register, both compare registers, the control register, the flag register and both waveform outputs are all zero.
- R2: A write to any high-byte address (0x85 counter, 0x87 capture, 0x89 compare A, 0x8B compare B) loads only the shared holding byte. A write to a low-byte address (0x84, 0x86, 0x88, 0x8A) commits {holding byte, written byte} to that register in one cycle, whichever high address filled the holding byte.
- R3: Reading a low-byte address returns the live low byte and copies that register's high byte into the holding byte. Reading any high-byte address returns the holding byte.
- R4: With top mode off, each cycle with the step strobe high adds one to the counter, and 0xFFFF steps to 0x0000. A bus commit to the counter in the same cycle wins over the step.
- R5: With top mode on (control bit 4), a step taken while the counter equals the capture register sends the counter to zero.
- R6: A step taken while the counter equals compare register A sets flag bit 0 at 0x36. For compare register B it sets flag bit 1.
- R7: A bus commit to the counter blocks compare matches on the next step only, and steps after that match normally.
- R8: When control bit 0 (unit A) or bit 1 (unit B) is set, each match of that unit toggles its waveform output. When the bit is clear the output holds.
- R9: Control bit 2 picks the capture source: 0 is the pin, 1 is the alternate input. Control bit 3 picks the edge: 1 is rising, 0 is falling. The chosen source passes through two synchronising flops, and a chosen edge loads the counter into the capture register and sets flag bit 2. Edges of the other polarity and activity on the unselected source have no effect.
- R10: Writing 0x36 clears each flag whose written bit is 1 and leaves flags with a written 0. A set in the same cycle wins over a clear.
- R11: The control register at 0x80 holds bits 4:0 and reads back bits 7:5 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-cycle timer step strobe |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Byte write strobe |
| wdata | input | 8 | Byte write data |
| rd_en | input | 1 | Byte read strobe (drives holding-byte snapshot) |
| rdata | output | 8 | Byte read data for addr |
| cap_pin | input | 1 | Capture pin, asynchronous |
| alt_cap | input | 1 | Alternate comparator capture input, asynchronous |
| wave_a | output | 1 | Compare A waveform |
| wave_b | output | 1 | Compare B waveform |

## Verification
The bench builds the block with its default of two synchronising stages, so a capture is visible three edges after the pin moves. At 16 bits the counter is small enough for the bench to drive a full 65,536-step lap and confirm that the counter comes back to its start value. Compare values are swept across the whole range, including the 0xFFFF-to-0 wrap. Top-mode wrap points are swept from 1 up to several hundred.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int N_CMP  = 2;
    localparam int CTRL_W = 5;

    localparam logic [7:0] A_FLAGS  = 8'h36;
    localparam logic [7:0] A_CTRL   = 8'h80;
    localparam logic [7:0] A_CNT_L  = 8'h84;
    localparam logic [7:0] A_CNT_H  = 8'h85;
    localparam logic [7:0] A_CAP_L  = 8'h86;
    localparam logic [7:0] A_CAP_H  = 8'h87;
    localparam logic [7:0] A_CMPA_L = 8'h88;
    localparam logic [7:0] A_CMPA_H = 8'h89;
    localparam logic [7:0] A_CMPB_L = 8'h8A;
    localparam logic [7:0] A_CMPB_H = 8'h8B;

    localparam int CB_SRC_ALT = 2;
    localparam int CB_RISE    = 3;
    localparam int CB_TOP     = 4;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CNT,
        TGT_CAP,
        TGT_CMPA,
        TGT_CMPB
    } wide_tgt_e;
endpackage

// File: rtl/tmr_capsync.sv
module tmr_capsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_alt,
    input  logic rise_sel,
    input  logic pin_in,
    input  logic alt_in,
    output logic evt
);
    logic              raw;
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    assign raw = use_alt ? alt_in : pin_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign evt = rise_sel ? (sync_q[STAGES-1] & ~prev_q)
                          : (~sync_q[STAGES-1] & prev_q);

    assert_evt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         blocked,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ocr,
    input  logic         wave_en,
    input  logic         clr,
    output logic         flag,
    output logic         wave
);
    logic hit;
    logic flag_q;
    logic wave_q;

    assign hit = tick && !blocked && (cnt == ocr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            wave_q <= 1'b0;
        end else begin
            if (hit)      flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
            if (hit && wave_en) wave_q <= ~wave_q;
        end
    end

    assign flag = flag_q;
    assign wave = wave_q;

    assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);
    assert_wave_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wave_en) |=> (wave_q != $past(wave_q)));
    assert_wave_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_en |=> $stable(wave_q));
endmodule

// File: rtl/tmr16_bytebus.sv
module tmr16_bytebus
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       rd_en,
    output logic [7:0] rdata,
    input  logic       cap_pin,
    input  logic       alt_cap,
    output logic       wave_a,
    output logic       wave_b
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wide_tgt_e         tgt;
    logic              hi_sel;
    logic [CNT_W-1:0]  live;
    logic [BYTE_W-1:0] temp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  icr_q;
    logic [CNT_W-1:0]  ocr_q [N_CMP];
    logic [CTRL_W-1:0] ctrl_q;
    logic              blk_q;
    logic              cap_flag_q;
    logic [N_CMP-1:0]  cmp_flag;
    logic [N_CMP-1:0]  wave;
    logic [N_CMP-1:0]  cmp_commit;
    logic [CNT_W-1:0]  commit_val;
    logic              lo_wr;
    logic              cnt_commit;
    logic              cap_commit;
    logic              flag_wr;
    logic              top_en;
    logic              cap_evt;

    // address decode into wide register target and byte half
    always_comb begin
        tgt    = TGT_NONE;
        hi_sel = 1'b0;
        case (addr)
            A_CNT_L:  tgt = TGT_CNT;
            A_CNT_H:  begin tgt = TGT_CNT;  hi_sel = 1'b1; end
            A_CAP_L:  tgt = TGT_CAP;
            A_CAP_H:  begin tgt = TGT_CAP;  hi_sel = 1'b1; end
            A_CMPA_L: tgt = TGT_CMPA;
            A_CMPA_H: begin tgt = TGT_CMPA; hi_sel = 1'b1; end
            A_CMPB_L: tgt = TGT_CMPB;
            A_CMPB_H: begin tgt = TGT_CMPB; hi_sel = 1'b1; end
            default:  ;
        endcase
    end

    always_comb begin
        unique case (tgt)
            TGT_CNT:  live = cnt_q;
            TGT_CAP:  live = icr_q;
            TGT_CMPA: live = ocr_q[0];
            TGT_CMPB: live = ocr_q[1];
            default:  live = '0;
        endcase
    end

    assign lo_wr         = wr_en && !hi_sel && (tgt != TGT_NONE);
    assign commit_val    = {temp_q, wdata};
    assign cnt_commit    = lo_wr && (tgt == TGT_CNT);
    assign cap_commit    = lo_wr && (tgt == TGT_CAP);
    assign cmp_commit[0] = lo_wr && (tgt == TGT_CMPA);
    assign cmp_commit[1] = lo_wr && (tgt == TGT_CMPB);
    assign flag_wr       = wr_en && (addr == A_FLAGS);
    assign top_en        = ctrl_q[CB_TOP];

    // shared holding byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else if (wr_en && hi_sel && (tgt != TGT_NONE)) begin
            temp_q <= wdata;
        end else if (rd_en && !wr_en && !hi_sel && (tgt != TGT_NONE)) begin
            temp_q <= live[CNT_W-1:BYTE_W];
        end
    end

    // counter and its one-step compare block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else begin
            if (cnt_commit) begin
                cnt_q <= commit_val;
                blk_q <= 1'b1;
            end else if (tick) begin
                cnt_q <= (top_en && (cnt_q == icr_q)) ? '0 : cnt_q + ONE;
                blk_q <= 1'b0;
            end
        end
    end

    // capture register, control register, capture flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icr_q      <= '0;
            ctrl_q     <= '0;
            cap_flag_q <= 1'b0;
        end else begin
            if (cap_evt)         icr_q <= cnt_q;
            else if (cap_commit) icr_q <= commit_val;
            if (wr_en && (addr == A_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
            if (cap_evt)                    cap_flag_q <= 1'b1;
            else if (flag_wr && wdata[2])   cap_flag_q <= 1'b0;
        end
    end

    tmr_capsync #(.STAGES(SYNC_STAGES)) u_capsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_alt  (ctrl_q[CB_SRC_ALT]),
        .rise_sel (ctrl_q[CB_RISE]),
        .pin_in   (cap_pin),
        .alt_in   (alt_cap),
        .evt      (cap_evt)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             ocr_q[g] <= '0;
            else if (cmp_commit[g]) ocr_q[g] <= commit_val;
        end

        tmr_cmp_unit #(.W(CNT_W)) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .blocked (blk_q),
            .cnt     (cnt_q),
            .ocr     (ocr_q[g]),
            .wave_en (ctrl_q[g]),
            .clr     (flag_wr && wdata[g]),
            .flag    (cmp_flag[g]),
            .wave    (wave[g])
        );
    end

    assign wave_a = wave[0];
    assign wave_b = wave[1];

    // byte read mux
    always_comb begin
        rdata = '0;
        if (tgt != TGT_NONE) begin
            rdata = hi_sel ? temp_q : live[BYTE_W-1:0];
        end else if (addr == A_FLAGS) begin
            rdata = {5'b0, cap_flag_q, cmp_flag};
        end else if (addr == A_CTRL) begin
            rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
        end
    end

    assert_temp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hi_sel && (tgt != TGT_NONE)) |=> (temp_q == $past(wdata)));
    assert_cmp_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_commit[0] |=> (ocr_q[0] == {$past(temp_q), $past(wdata)}));
    assert_rd_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !hi_sel && (tgt != TGT_NONE))
            |=> (temp_q == $past(live[CNT_W-1:BYTE_W])));
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_commit && !(top_en && (cnt_q == icr_q)))
            |=> (cnt_q == $past(cnt_q) + ONE));
    assert_top_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_commit && top_en && (cnt_q == icr_q)) |=> (cnt_q == '0));
    assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q && tick) |=> !$rose(cmp_flag[0]) && !$rose(cmp_flag[1]));
    assert_cap_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (icr_q == $past(cnt_q)) && cap_flag_q);
endmodule

// File: tb/tmr16_bytebus_tb.sv
`timescale 1ns/1ps
module tmr16_bytebus_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       cap_pin = 1'b0;
    logic       alt_cap = 1'b0;
    logic       wave_a;
    logic       wave_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr16_bytebus u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .cap_pin(cap_pin),
        .alt_cap(alt_cap), .wave_a(wave_a), .wave_b(wave_b)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr16(input logic [7:0] lo, input logic [15:0] v);
        wr(lo + 8'd1, v[15:8]);
        wr(lo, v[7:0]);
    endtask

    task automatic rd16(input logic [7:0] lo, output logic [15:0] v);
        logic [7:0] l;
        logic [7:0] h;
        rd(lo, l);
        rd(lo + 8'd1, h);
        v = {h, l};
    endtask

    task automatic step(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        int          flips;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            rd16(8'h84 + 8'(2 * r), v);
            chk("R1 wide reg reset", v, 16'h0000);
        end
        rd(8'h36, b); chk("R1 flags reset", {8'h0, b}, 16'h0000);
        rd(8'h80, b); chk("R1 ctrl reset", {8'h0, b}, 16'h0000);
        chk("R1 waves reset", {14'h0, wave_b, wave_a}, 16'h0000);

        // R11 control readback
        wr(8'h80, 8'hFF); rd(8'h80, b); chk("R11 ctrl mask", {8'h0, b}, 16'h001F);
        wr(8'h80, 8'h00);

        // R2 write/read round trip, swept
        for (int k = 0; k < 16; k++) begin
            v = 16'(k * 16'h1111 + 16'h0F0E);
            wr16(8'h88, v);
            wr16(8'h8A, ~v);
            wr16(8'h86, v ^ 16'h5A5A);
            rd16(8'h88, v); chk("R2 cmpA roundtrip", v, 16'(k * 16'h1111 + 16'h0F0E));
            rd16(8'h8A, v); chk("R2 cmpB roundtrip", v, ~16'(k * 16'h1111 + 16'h0F0E));
            rd16(8'h86, v); chk("R2 cap roundtrip", v, 16'(k * 16'h1111 + 16'h0F0E) ^ 16'h5A5A);
        end
        // R2 shared holding byte across registers
        wr16(8'h88, 16'h1111);
        wr(8'h89, 8'hAB);
        wr(8'h8A, 8'hCD);
        rd16(8'h8A, v); chk("R2 shared temp into B", v, 16'hABCD);
        rd16(8'h88, v); chk("R2 A untouched", v, 16'h1111);

        // R3 read snapshot
        wr16(8'h84, 16'h12FF);
        rd(8'h84, b); chk("R3 low live", {8'h0, b}, 16'h00FF);
        step(1);
        rd(8'h85, b); chk("R3 high from snapshot", {8'h0, b}, 16'h0012);
        rd16(8'h84, v); chk("R3 fresh read", v, 16'h1300);

        // R4 wrap, write-over-step, full lap
        wr16(8'h84, 16'hFFFE);
        step(2);
        rd16(8'h84, v); chk("R4 wrap to zero", v, 16'h0000);
        wr(8'h85, 8'h40);
        addr = 8'h84; wdata = 8'h00; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd16(8'h84, v); chk("R4 write beats step", v, 16'h4000);
        wr16(8'h84, 16'h1357);
        step(65536);
        rd16(8'h84, v); chk("R4 full lap", v, 16'h1357);

        // R6/R8 compare sweep on unit A with toggle enabled
        wr(8'h36, 8'h07);
        wr(8'h80, 8'h01);
        flips = 0;
        for (int k = 0; k < 17; k++) begin
            v = (k == 16) ? 16'h0000 : 16'(k * 4099 + 3);
            wr16(8'h88, v);
            wr16(8'h8A, v ^ 16'h8000);
            wr(8'h36, 8'h07);
            wr16(8'h84, v - 16'd1);
            step(1);
            rd(8'h36, b); chk("R6 no flag before match", {8'h0, b}, 16'h0000);
            step(1);
            flips++;
            rd(8'h36, b); chk("R6 flag A on match", {8'h0, b}, 16'h0001);
            chk("R8 wave A toggles", {15'h0, wave_a}, 16'(flips % 2));
        end
        // unit B with toggle disabled
        wr(8'h36, 8'h07);
        wr16(8'h8A, 16'h0200);
        wr16(8'h84, 16'h01FF);
        step(2);
        rd(8'h36, b); chk("R6 flag B on match", {8'h0, b}, 16'h0002);
        chk("R8 wave B holds", {15'h0, wave_b}, 16'h0000);

        // R10 selective clear
        wr(8'h36, 8'h01);
        rd(8'h36, b); chk("R10 zero bit keeps flag", {8'h0, b}, 16'h0002);
        wr(8'h36, 8'h02);
        rd(8'h36, b); chk("R10 one bit clears", {8'h0, b}, 16'h0000);

        // R7 block after counter write, one step only
        wr(8'h80, 8'h00);
        wr16(8'h88, 16'h0777);
        wr16(8'h84, 16'h0777);
        step(1);
        rd(8'h36, b); chk("R7 match blocked", {8'h0, b}, 16'h0000);
        wr16(8'h84, 16'h0776);
        step(1);
        step(1);
        rd(8'h36, b); chk("R7 later step matches", {8'h0, b}, 16'h0001);
        wr(8'h36, 8'h07);

        // R5 top mode sweep
        wr(8'h80, 8'h10);
        for (int k = 0; k < 5; k++) begin
            int t;
            t = (k == 4) ? 300 : k + 1;
            wr16(8'h86, 16'(t));
            wr16(8'h84, 16'h0000);
            step(t);
            rd16(8'h84, v); chk("R5 reaches top", v, 16'(t));
            step(1);
            rd16(8'h84, v); chk("R5 wraps at top", v, 16'h0000);
        end

        // R9 capture: rising on pin
        wr(8'h80, 8'h08);
        wr(8'h36, 8'h07);
        wr16(8'h84, 16'h1234);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd16(8'h86, v); chk("R9 rising pin capture", v, 16'h1234);
        rd(8'h36, b); chk("R9 capture flag", {8'h0, b}, 16'h0004);
        wr(8'h36, 8'h04);
        // falling mode
        wr(8'h80, 8'h00);
        repeat (4) @(negedge clk);
        wr16(8'h84, 16'h2222);
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd16(8'h86, v); chk("R9 falling pin capture", v, 16'h2222);
        wr(8'h36, 8'h04);
        wr16(8'h84, 16'h3333);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd16(8'h86, v); chk("R9 wrong edge ignored", v, 16'h2222);
        rd(8'h36, b); chk("R9 no flag on wrong edge", {8'h0, b}, 16'h0000);
        // alternate source, rising
        wr(8'h80, 8'h0C);
        repeat (4) @(negedge clk);
        wr(8'h36, 8'h04);
        wr16(8'h84, 16'h4444);
        alt_cap = 1'b1;
        repeat (4) @(negedge clk);
        rd16(8'h86, v); chk("R9 alt capture", v, 16'h4444);
        wr16(8'h84, 16'h5555);
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd16(8'h86, v); chk("R9 pin ignored with alt", v, 16'h4444);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule